// File: doc/BRIEF.md
# AUX Reply Status Classifier

Once an auxiliary-channel transaction has been sent, this block waits for the receiver to report completion. It then turns the receiver's status into a single outcome code and extracts the reply from the received bytes. The caller arms it with a one-cycle start pulse. The receiver side supplies a done strobe, a set of error flags, a hot-plug-loss flag, a received byte count and the received byte buffer. One cycle after done is sampled, the block presents the outcome code, the 4-bit reply code, the number of payload bytes delivered, an overflow flag and the delivered payload bytes.

The classification follows a fixed priority. Each test is applied only when every test above it has passed:

1. Loss of the sink.
2. Any receive timeout.
3. Malformed reply symbols.
4. An empty reply.

A reply that passes all four is a good reply. Its first byte carries the reply code in its upper four bits. When that code is an acknowledge, the bytes after the first one are handed to the caller. This happens only if they fit within the smaller of the caller's stated capacity and the block's own payload width. Otherwise an overflow is reported and nothing is delivered. If done never comes, a programmable limit on armed cycles ends the wait with a timeout outcome.

Top module: `aux_reply_classifier`

## Requirements
- R1: After reset, result valid, outcome, reply code, data count, overflow and every data byte are zero, and the block is idle.
- R2: A start pulse while idle arms the block. While armed, further start pulses are ignored and do not restart the wait. While idle, done is ignored. The cycle that samples done while armed ends the wait. Result valid is high for exactly the next cycle, and the result fields hold until the next result.
- R3: If the hot-plug-loss flag is set when done is sampled, the outcome is disconnect (code 3), whatever the other flags and count are.
- R4: Otherwise, if either receive timeout flag is set, the outcome is timeout (code 1), even if invalid-symbol flags are also set.
- R5: Otherwise, if any of the bad-stop, no-detect, bad-high or bad-low flags is set, the outcome is invalid reply (code 2).
- R6: The minimum-count-violation flag never changes any output.
- R7: With no error flag set, a received count of zero gives an invalid reply (code 2). Any other count gives a good outcome (code 0).
- R8: On a good outcome, the reply code is bits 7:4 of received byte 0 (bits 7:0 of the buffer). On any other outcome, the reply code is 0.
- R9: On a good outcome with reply code 0 (acknowledge) and no overflow, the data count is the received count minus one. Output byte k (bits 8k+7:8k) equals received byte k+1, and output bytes at or beyond the count are zero.
- R10: On an acknowledge, if the received count minus one exceeds the smaller of the capacity input and the payload width (buffer bytes minus one), overflow is set, the data count is zero and all data bytes are zero. The outcome stays good.
- R11: For a non-acknowledge reply code, and for every non-good outcome, the data count, overflow and all data bytes are zero.
- R12: If done is not sampled in the first max(limit,1) armed cycles, the result is a timeout outcome with zero reply and data. Done sampled in the last such cycle wins over the expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Arms the block when idle |
| done_i | input | 1 | Receiver completion strobe |
| limit_i | input | LIM_W | Armed-cycle limit before timeout |
| hpd_lost_i | input | 1 | Sink disconnected |
| rx_tmo_i | input | 1 | Receive timeout |
| rx_tmo_state_i | input | 1 | Receiver in timeout state |
| bad_stop_i | input | 1 | Invalid stop condition |
| no_detect_i | input | 1 | Reply not detected |
| bad_high_i | input | 1 | Invalid high symbol |
| bad_low_i | input | 1 | Invalid low symbol |
| min_cnt_i | input | 1 | Debug count-violation flag, ignored |
| rx_count_i | input | CNT_W | Received byte count including status byte |
| rx_bytes_i | input | BUF_BYTES*8 | Received bytes, byte 0 in bits 7:0 |
| capacity_i | input | CNT_W | Caller buffer capacity in bytes |
| res_valid_o | output | 1 | One-cycle result strobe |
| outcome_o | output | 2 | 0 good, 1 timeout, 2 invalid, 3 disconnect |
| reply_o | output | 4 | Reply code |
| data_count_o | output | CNT_W | Payload bytes delivered |
| overflow_o | output | 1 | Payload larger than capacity |
| data_o | output | (BUF_BYTES-1)*8 | Delivered payload, byte k in bits 8k+7:8k |

## Verification
On every cycle, the bound checker enforces several properties whenever done is sampled while armed:

- the priority chain of disconnect, then timeout, then invalid symbols, then empty reply;
- the single-cycle result strobe;
- the zeroing of payload on overflow or a non-acknowledge reply.

The order of delivered bytes and the capacity clamp can only be shown by the bench's sweeps, which cover every flag combination and every count, capacity and reply-code pairing. So can the exact cycle on which the armed-cycle limit expires and the fact that a late start cannot restart the wait.

// File: rtl/aux_cls_pkg.sv
package aux_cls_pkg;

    typedef enum logic [1:0] {
        OUT_OK      = 2'd0,
        OUT_TIMEOUT = 2'd1,
        OUT_INVALID = 2'd2,
        OUT_DISCON  = 2'd3
    } outcome_e;

    typedef struct packed {
        logic hpd_lost;
        logic rx_tmo;
        logic rx_tmo_state;
        logic bad_stop;
        logic no_detect;
        logic bad_high;
        logic bad_low;
        logic min_cnt;
    } rx_flags_t;

    localparam logic [3:0] REPLY_ACK = 4'h0;

    // Fixed-priority outcome; min_cnt deliberately takes no part.
    function automatic outcome_e classify(input rx_flags_t f, input logic cnt_zero);
        outcome_e r;
        if (f.hpd_lost)
            r = OUT_DISCON;
        else if (f.rx_tmo || f.rx_tmo_state)
            r = OUT_TIMEOUT;
        else if (f.bad_stop || f.no_detect || f.bad_high || f.bad_low)
            r = OUT_INVALID;
        else if (cnt_zero)
            r = OUT_INVALID;
        else
            r = OUT_OK;
        return r;
    endfunction

endpackage

// File: rtl/aux_wait_timer.sv
module aux_wait_timer #(
    parameter int LIM_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             done_i,
    input  logic [LIM_W-1:0] limit_i,
    output logic             armed_o,
    output logic             finish_o,
    output logic             expire_o
);
    logic             busy_q;
    logic [LIM_W-1:0] cnt_q;
    logic [LIM_W:0]   next_cnt;

    assign next_cnt = {1'b0, cnt_q} + (LIM_W+1)'(1);
    assign armed_o  = busy_q;
    assign finish_o = busy_q && done_i;
    assign expire_o = busy_q && !done_i && (next_cnt >= {1'b0, limit_i});

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end
        end else if (finish_o || expire_o) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= next_cnt[LIM_W-1:0];
        end
    end
endmodule

// File: rtl/aux_outcome_decode.sv
module aux_outcome_decode
    import aux_cls_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int DATA_MAX = 16
) (
    input  rx_flags_t          flags_i,
    input  logic [CNT_W-1:0]   rx_count_i,
    input  logic [3:0]         status_hi_i,
    input  logic [CNT_W-1:0]   capacity_i,
    output outcome_e           outcome_o,
    output logic [3:0]         reply_o,
    output logic               deliver_o,
    output logic               overflow_o,
    output logic [CNT_W-1:0]   n_data_o
);
    localparam logic [CNT_W-1:0] MAXD = CNT_W'(DATA_MAX);

    logic             good;
    logic             is_ack;
    logic [CNT_W-1:0] payload_len;
    logic [CNT_W-1:0] eff_cap;

    always_comb begin
        outcome_o   = classify(flags_i, rx_count_i == '0);
        good        = (outcome_o == OUT_OK);
        reply_o     = good ? status_hi_i : 4'h0;
        is_ack      = good && (status_hi_i == REPLY_ACK);
        payload_len = rx_count_i - CNT_W'(1);
        eff_cap     = (capacity_i > MAXD) ? MAXD : capacity_i;
        overflow_o  = is_ack && (payload_len > eff_cap);
        deliver_o   = is_ack && !overflow_o;
        n_data_o    = deliver_o ? payload_len : '0;
    end
endmodule

// File: rtl/aux_payload_unpack.sv
module aux_payload_unpack #(
    parameter int CNT_W    = 5,
    parameter int DATA_MAX = 16
) (
    input  logic [DATA_MAX*8-1:0] payload_i,
    input  logic                  deliver_i,
    input  logic [CNT_W-1:0]      n_data_i,
    output logic [DATA_MAX*8-1:0] data_o
);
    for (genvar k = 0; k < DATA_MAX; k++) begin : g_lane
        localparam logic [CNT_W-1:0] K_IDX = CNT_W'(k);
        assign data_o[k*8 +: 8] = (deliver_i && (K_IDX < n_data_i)) ? payload_i[k*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/aux_reply_classifier.sv
module aux_reply_classifier
    import aux_cls_pkg::*;
#(
    parameter  int BUF_BYTES = 17,
    parameter  int LIM_W     = 16,
    localparam int CNT_W     = $clog2(BUF_BYTES + 1),
    localparam int DATA_MAX  = BUF_BYTES - 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    done_i,
    input  logic [LIM_W-1:0]        limit_i,
    input  logic                    hpd_lost_i,
    input  logic                    rx_tmo_i,
    input  logic                    rx_tmo_state_i,
    input  logic                    bad_stop_i,
    input  logic                    no_detect_i,
    input  logic                    bad_high_i,
    input  logic                    bad_low_i,
    input  logic                    min_cnt_i,
    input  logic [CNT_W-1:0]        rx_count_i,
    input  logic [BUF_BYTES*8-1:0]  rx_bytes_i,
    input  logic [CNT_W-1:0]        capacity_i,
    output logic                    res_valid_o,
    output logic [1:0]              outcome_o,
    output logic [3:0]              reply_o,
    output logic [CNT_W-1:0]        data_count_o,
    output logic                    overflow_o,
    output logic [DATA_MAX*8-1:0]   data_o
);
    rx_flags_t             flags;
    logic                  armed;
    logic                  finish;
    logic                  expire;
    outcome_e              dec_outcome;
    logic [3:0]            dec_reply;
    logic                  dec_deliver;
    logic                  dec_overflow;
    logic [CNT_W-1:0]      dec_count;
    logic [DATA_MAX*8-1:0] dec_data;

    assign flags = '{hpd_lost:     hpd_lost_i,
                     rx_tmo:       rx_tmo_i,
                     rx_tmo_state: rx_tmo_state_i,
                     bad_stop:     bad_stop_i,
                     no_detect:    no_detect_i,
                     bad_high:     bad_high_i,
                     bad_low:      bad_low_i,
                     min_cnt:      min_cnt_i};

    aux_wait_timer #(.LIM_W(LIM_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .done_i   (done_i),
        .limit_i  (limit_i),
        .armed_o  (armed),
        .finish_o (finish),
        .expire_o (expire)
    );

    aux_outcome_decode #(.CNT_W(CNT_W), .DATA_MAX(DATA_MAX)) u_decode (
        .flags_i     (flags),
        .rx_count_i  (rx_count_i),
        .status_hi_i (rx_bytes_i[7:4]),
        .capacity_i  (capacity_i),
        .outcome_o   (dec_outcome),
        .reply_o     (dec_reply),
        .deliver_o   (dec_deliver),
        .overflow_o  (dec_overflow),
        .n_data_o    (dec_count)
    );

    aux_payload_unpack #(.CNT_W(CNT_W), .DATA_MAX(DATA_MAX)) u_unpack (
        .payload_i (rx_bytes_i[BUF_BYTES*8-1:8]),
        .deliver_i (dec_deliver),
        .n_data_i  (dec_count),
        .data_o    (dec_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid_o  <= 1'b0;
            outcome_o    <= OUT_OK;
            reply_o      <= 4'h0;
            data_count_o <= '0;
            overflow_o   <= 1'b0;
            data_o       <= '0;
        end else begin
            res_valid_o <= finish || expire;
            if (finish) begin
                outcome_o    <= dec_outcome;
                reply_o      <= dec_reply;
                data_count_o <= dec_count;
                overflow_o   <= dec_overflow;
                data_o       <= dec_data;
            end else if (expire) begin
                outcome_o    <= OUT_TIMEOUT;
                reply_o      <= 4'h0;
                data_count_o <= '0;
                overflow_o   <= 1'b0;
                data_o       <= '0;
            end
        end
    end
endmodule

// File: rtl/aux_cls_checker.sv
module aux_cls_checker #(
    parameter int CNT_W    = 5,
    parameter int DATA_MAX = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  armed,
    input logic                  done_i,
    input logic                  hpd_lost_i,
    input logic                  rx_tmo_i,
    input logic                  rx_tmo_state_i,
    input logic                  bad_any,
    input logic                  min_cnt_i,
    input logic [CNT_W-1:0]      rx_count_i,
    input logic                  res_valid_o,
    input logic [1:0]            outcome_o,
    input logic [3:0]            reply_o,
    input logic [CNT_W-1:0]      data_count_o,
    input logic                  overflow_o,
    input logic [DATA_MAX*8-1:0] data_o
);
    logic sampled;
    logic tmo_any;
    assign sampled = armed && done_i;
    assign tmo_any = rx_tmo_i || rx_tmo_state_i;

    p_discon_first_r3: assert property (@(posedge clk) disable iff (rst)
        sampled && hpd_lost_i |=> res_valid_o && outcome_o == 2'd3);

    p_tmo_over_bad_r4: assert property (@(posedge clk) disable iff (rst)
        sampled && !hpd_lost_i && tmo_any |=> outcome_o == 2'd1);

    p_bad_symbols_r5: assert property (@(posedge clk) disable iff (rst)
        sampled && !hpd_lost_i && !tmo_any && bad_any |=> outcome_o == 2'd2);

    p_debug_flag_r6: assert property (@(posedge clk) disable iff (rst)
        sampled && min_cnt_i && !hpd_lost_i && !tmo_any && !bad_any && rx_count_i != '0
        |=> outcome_o == 2'd0);

    p_empty_reply_r7: assert property (@(posedge clk) disable iff (rst)
        sampled && !hpd_lost_i && !tmo_any && !bad_any && rx_count_i == '0 |=> outcome_o == 2'd2);

    p_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |=> !res_valid_o);

    p_from_armed_r2: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> $past(armed));

    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> data_count_o <= CNT_W'(DATA_MAX));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        res_valid_o && overflow_o |-> data_count_o == '0 && data_o == '0 && outcome_o == 2'd0);

    p_nonack_empty_r11: assert property (@(posedge clk) disable iff (rst)
        res_valid_o && (reply_o != 4'h0 || outcome_o != 2'd0)
        |-> data_count_o == '0 && data_o == '0 && !overflow_o);
endmodule

bind aux_reply_classifier aux_cls_checker #(.CNT_W(CNT_W), .DATA_MAX(DATA_MAX)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .armed          (armed),
    .done_i         (done_i),
    .hpd_lost_i     (hpd_lost_i),
    .rx_tmo_i       (rx_tmo_i),
    .rx_tmo_state_i (rx_tmo_state_i),
    .bad_any        (bad_stop_i | no_detect_i | bad_high_i | bad_low_i),
    .min_cnt_i      (min_cnt_i),
    .rx_count_i     (rx_count_i),
    .res_valid_o    (res_valid_o),
    .outcome_o      (outcome_o),
    .reply_o        (reply_o),
    .data_count_o   (data_count_o),
    .overflow_o     (overflow_o),
    .data_o         (data_o)
);

// File: tb/sim_aux_reply_classifier.sv
module sim_aux_reply_classifier;
    localparam int BUF_BYTES = 5;
    localparam int LIM_W     = 4;
    localparam int CNT_W     = $clog2(BUF_BYTES + 1);
    localparam int DATA_MAX  = BUF_BYTES - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, done_i = 1'b0;
    logic [LIM_W-1:0] limit_i = 4'd15;
    logic [7:0] fl = 8'h00;
    logic [CNT_W-1:0] rx_count_i = '0, capacity_i = '0;
    logic [BUF_BYTES*8-1:0] rx_bytes_i = '0;
    logic res_valid_o, overflow_o;
    logic [1:0] outcome_o;
    logic [3:0] reply_o;
    logic [CNT_W-1:0] data_count_o;
    logic [DATA_MAX*8-1:0] data_o;

    int tests = 0, fails = 0, cycles = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    aux_reply_classifier #(.BUF_BYTES(BUF_BYTES), .LIM_W(LIM_W)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .done_i(done_i), .limit_i(limit_i),
        .hpd_lost_i(fl[7]), .rx_tmo_i(fl[6]), .rx_tmo_state_i(fl[5]), .bad_stop_i(fl[4]),
        .no_detect_i(fl[3]), .bad_high_i(fl[2]), .bad_low_i(fl[1]), .min_cnt_i(fl[0]),
        .rx_count_i(rx_count_i), .rx_bytes_i(rx_bytes_i), .capacity_i(capacity_i),
        .res_valid_o(res_valid_o), .outcome_o(outcome_o), .reply_o(reply_o),
        .data_count_o(data_count_o), .overflow_o(overflow_o), .data_o(data_o)
    );

    task automatic chk(input bit ok, input string req, input string msg);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    function automatic logic [7:0] pbyte(input int j);
        return 8'(8'h40 + j * 13);
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // One armed transaction with done on the first armed cycle.
    task automatic txn(input logic [7:0] f, input int cnt, input logic [7:0] st, input int cap,
                       input string req);
        int eo, er, plen, ecap, en;
        bit ack, eovf;
        logic [DATA_MAX*8-1:0] ed;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) begin
            start_i = 1'b0;
            done_i = 1'b1;
            fl = f;
            rx_count_i = CNT_W'(cnt);
            capacity_i = CNT_W'(cap);
            rx_bytes_i[7:0] = st;
            for (int j = 1; j < BUF_BYTES; j++) rx_bytes_i[j*8 +: 8] = pbyte(j);
        end
        @(negedge clk) done_i = 1'b0;
        if (f[7]) eo = 3;
        else if (f[6] || f[5]) eo = 1;
        else if (|f[4:1]) eo = 2;
        else if (cnt == 0) eo = 2;
        else eo = 0;
        er   = (eo == 0) ? int'(st[7:4]) : 0;
        ack  = (eo == 0) && (er == 0);
        plen = cnt - 1;
        ecap = (cap > DATA_MAX) ? DATA_MAX : cap;
        eovf = ack && (plen > ecap);
        en   = (ack && !eovf) ? plen : 0;
        for (int k = 0; k < DATA_MAX; k++) ed[k*8 +: 8] = (k < en) ? pbyte(k + 1) : 8'h00;
        chk(res_valid_o === 1'b1 && int'(outcome_o) == eo && int'(reply_o) == er &&
            int'(data_count_o) == en && overflow_o === eovf && data_o === ed, req,
            $sformatf("f=%h cnt=%0d st=%h cap=%0d act v%b o%0d r%0d n%0d ov%b d%h exp v1 o%0d r%0d n%0d ov%b d%h",
                      f, cnt, st, cap, res_valid_o, outcome_o, reply_o, data_count_o, overflow_o,
                      data_o, eo, er, en, eovf, ed));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !ended) begin
            tests++;
            fails++;
            $display("FAIL watchdog: act hung exp finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(res_valid_o === 1'b0 && outcome_o === 2'd0 && reply_o === 4'h0 &&
            data_count_o === '0 && overflow_o === 1'b0 && data_o === '0, "R1",
            $sformatf("act v%b o%0d r%0d n%0d ov%b d%h exp all zero", res_valid_o, outcome_o,
                      reply_o, data_count_o, overflow_o, data_o));

        // R3 R4 R5 R6: every flag combination
        for (int f = 0; f < 256; f++) begin
            string t;
            if (f[7]) t = "R3";
            else if (f[6] || f[5]) t = "R4";
            else if (|f[4:1]) t = "R5";
            else t = "R6";
            txn(8'(f), 3, 8'h00, 4, t);
        end

        // R7 R8 R9 R10 R11: count x capacity x reply code
        for (int c = 0; c < 8; c++)
            for (int cp = 0; cp < 8; cp++)
                for (int nb = 0; nb < 16; nb++) begin
                    string t;
                    if (c == 0) t = "R7";
                    else if (nb != 0) t = "R8/R11";
                    else if (c - 1 > ((cp > DATA_MAX) ? DATA_MAX : cp)) t = "R10";
                    else t = "R9";
                    txn(8'h01, c, 8'((nb << 4) | 5), cp, t);
                end

        // R2: result strobe lasts one cycle, fields hold
        txn(8'h00, 2, 8'h00, 4, "R9");
        @(negedge clk);
        chk(res_valid_o === 1'b0 && data_count_o == 1 && data_o[7:0] == pbyte(1), "R2",
            $sformatf("act v%b n%0d exp v0 n1 held", res_valid_o, data_count_o));
        // R2: done while idle ignored
        fl = 8'h80;
        done_i = 1'b1;
        @(negedge clk) done_i = 1'b0;
        @(negedge clk);
        chk(res_valid_o === 1'b0 && outcome_o === 2'd0, "R2",
            $sformatf("idle done act v%b o%0d exp v0 o0", res_valid_o, outcome_o));
        fl = 8'h00;

        // R12: expiry after limit armed cycles
        limit_i = 4'd3;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(res_valid_o === 1'b0, "R12", $sformatf("early act v%b exp 0", res_valid_o));
        @(negedge clk);
        chk(res_valid_o === 1'b1 && outcome_o === 2'd1 && reply_o === 4'h0 && data_count_o === '0,
            "R12", $sformatf("expiry act v%b o%0d exp v1 o1", res_valid_o, outcome_o));

        // R12: limit zero behaves as one
        limit_i = 4'd0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        @(negedge clk);
        chk(res_valid_o === 1'b1 && outcome_o === 2'd1, "R12",
            $sformatf("limit0 act v%b o%0d exp v1 o1", res_valid_o, outcome_o));

        // R12: done in the last allowed cycle wins
        limit_i = 4'd3;
        rx_count_i = CNT_W'(1);
        rx_bytes_i[7:0] = 8'h00;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        @(negedge clk);
        @(negedge clk) done_i = 1'b1;
        @(negedge clk) done_i = 1'b0;
        chk(res_valid_o === 1'b1 && outcome_o === 2'd0, "R12",
            $sformatf("late done act v%b o%0d exp v1 o0", res_valid_o, outcome_o));

        // R2: start while armed does not restart the wait
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) begin
            chk(res_valid_o === 1'b0, "R2", $sformatf("rearm act v%b exp 0", res_valid_o));
            start_i = 1'b0;
        end
        @(negedge clk);
        chk(res_valid_o === 1'b1 && outcome_o === 2'd1, "R2",
            $sformatf("rearm expiry act v%b o%0d exp v1 o1", res_valid_o, outcome_o));
        repeat (5) @(negedge clk);
        chk(res_valid_o === 1'b0, "R2", $sformatf("no second result act v%b exp 0", res_valid_o));

        finish_run();
    end
endmodule